// File: doc/BRIEF.md
# Serial Berlekamp-Massey Key Equation Solver

The block takes up to sixteen Reed-Solomon syndromes over GF(2^8) and produces the error-locator polynomial and the error-evaluator polynomial for a decoder that corrects up to t symbol errors, with t chosen per codeword from 1 to 8. It runs the inversionless Berlekamp-Massey recursion one coefficient per clock on a small shared multiply-and-XOR cell. While the locator coefficients of one step are rewritten, the discrepancy for the next step is accumulated, so each step costs its new locator degree plus three cycles.

A codeword's syndromes are handed over with a start/ready handshake. When the run ends, a one-cycle done strobe marks the locator coefficients, the degree, a failure flag and the evaluator coefficients as valid. These stay unchanged until the next accepted start. A root search and magnitude stage downstream consumes them.

Top module: `bm_key_solver`

## Requirements
- R1: After reset, ready_o is 1, done_o is 0, deg_o is 0, fail_o is 0, and lam_o and omg_o are all zero.
- R2: A start is accepted only on a clock edge where start_i and ready_o are both 1. syn_i and t_i are captured on that edge, and ready_o is 0 from the next cycle until the run ends. A start_i pulse while ready_o is 0 has no effect on the results.
- R3: done_o is high for exactly one cycle, and ready_o is 1 in the cycle after it. lam_o, omg_o and deg_o do not change while ready_o is 1 and no start is accepted.
- R4: Arithmetic is in GF(2^8) with field polynomial x^8+x^4+x^3+x^2+1 and primitive element alpha=2. syn_i bits [8(j-1)+7:8(j-1)] carry S_j = r(alpha^j), for j=1..2t. lam_o bits [8i+7:8i] carry the coefficient of x^i. For v <= t errors: deg_o = v; coefficient 0 is nonzero; coefficients above v are zero; and the locator evaluates to zero at alpha^(-p) for every error position p.
- R5: omg_o bits [8i+7:8i] hold coefficient i (for i < t) of S(x)·Lambda(x) mod x^t, where S(x) = S_1 + S_2 x + S_3 x^2 + .... For v <= t errors, coefficients i >= v are zero, and each error value equals omega(alpha^-p) / Lambda'(alpha^-p).
- R6: fail_o is 1 exactly when the final degree deg_o exceeds the selected t.
- R7: t_i selects t. Syndromes S_j with j > 2t are ignored. A t_i value of 0 or above 8 selects t = 8.
- R8: With v <= t errors, done_o rises no more than 2t(v+3) + t(t+1)/2 clock edges after the accepting edge.
- R9: All-zero syndromes yield deg_o = 0, fail_o = 0, a nonzero constant locator and an all-zero evaluator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to load a syndrome set |
| ready_o | output | 1 | Idle; a start is accepted |
| t_i | input | 4 | Correction capability t for this codeword |
| syn_i | input | 128 | Syndromes S_1..S_16, S_1 in the low byte |
| done_o | output | 1 | One-cycle strobe: results are valid |
| fail_o | output | 1 | Final degree exceeds t |
| deg_o | output | 5 | Final locator degree |
| lam_o | output | 72 | Locator coefficients 0..8, x^0 in the low byte |
| omg_o | output | 64 | Evaluator coefficients 0..7, x^0 in the low byte |

## Verification
The bench builds syndromes from random error positions and values and checks the locator by its roots and the evaluator through the magnitude formula, so any scaling of the inversionless result is accepted. Zero discrepancies in the middle of a run, a single error at position 0, and a locator whose degree jumps past t all stress the decision logic. An update that read the saved polynomial after overwriting it would leave roots misplaced and make the magnitude check fail. Syndromes beyond 2t are filled with junk, and a start is pulsed while busy: a design that read the junk or restarted would return a wrong degree or misplaced roots. The start-to-done count is compared with the per-step bound, which catches a controller that stalls instead of overlapping.

// File: rtl/bmks_pkg.sv
package bmks_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEC,
    ST_UPD,
    ST_TAIL,
    ST_EVAL,
    ST_DONE
  } bmks_state_e;
endpackage

// File: rtl/bmks_gf_mult.sv
module bmks_gf_mult #(
  parameter int            SW        = 8,
  parameter logic [SW-1:0] POLY_TAIL = 8'h1D
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  output logic [SW-1:0] p_o
);
  logic [SW-1:0] part [SW+1];

  assign part[0] = '0;
  // MSB-first Horner: part = part*x + b_bit*a
  for (genvar i = 0; i < SW; i++) begin : g_row
    logic [SW-1:0] shl;
    assign shl         = {part[i][SW-2:0], 1'b0} ^ (part[i][SW-1] ? POLY_TAIL : '0);
    assign part[i+1]   = shl ^ (b_i[SW-1-i] ? a_i : '0);
  end

  assign p_o = part[SW];
endmodule

// File: rtl/bmks_pe.sv
module bmks_pe #(
  parameter int            SW        = 8,
  parameter logic [SW-1:0] POLY_TAIL = 8'h1D
) (
  input  logic [SW-1:0] x1_i,
  input  logic [SW-1:0] y1_i,
  input  logic [SW-1:0] x2_i,
  input  logic [SW-1:0] y2_i,
  output logic [SW-1:0] z_o
);
  logic [SW-1:0] p1, p2;

  bmks_gf_mult #(.SW(SW), .POLY_TAIL(POLY_TAIL)) u_m1 (.a_i(x1_i), .b_i(y1_i), .p_o(p1));
  bmks_gf_mult #(.SW(SW), .POLY_TAIL(POLY_TAIL)) u_m2 (.a_i(x2_i), .b_i(y2_i), .p_o(p2));

  assign z_o = p1 ^ p2;
endmodule

// File: rtl/bm_key_solver.sv
module bm_key_solver
  import bmks_pkg::*;
#(
  parameter int            SW        = 8,
  parameter int            TM        = 8,
  parameter logic [SW-1:0] POLY_TAIL = 8'h1D,
  localparam int NS  = 2 * TM,
  localparam int TW  = $clog2(TM + 1),
  localparam int RW  = $clog2(NS + 1),
  localparam int JW  = $clog2(TM + 1),
  localparam int SIW = $clog2(NS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  output logic                 ready_o,
  input  logic [TW-1:0]        t_i,
  input  logic [NS*SW-1:0]     syn_i,
  output logic                 done_o,
  output logic                 fail_o,
  output logic [RW-1:0]        deg_o,
  output logic [(TM+1)*SW-1:0] lam_o,
  output logic [TM*SW-1:0]     omg_o
);
  localparam logic [SW-1:0] ONE = SW'(1);

  bmks_state_e   st_q;
  logic [SW-1:0] syn_q [NS];
  logic [SW-1:0] lam_q [TM+1];
  logic [SW-1:0] bb_q  [TM+1];
  logic [SW-1:0] om_q  [TM];
  logic [RW-1:0] len_q, lnew_q, kof_q, r_q;
  logic [TW-1:0] t_q;
  logic [JW-1:0] j_q, lnj_q, ei_q, ej_q;
  logic [SW-1:0] gam_q, dlt_q, acc_q, lnq_q;
  logic          lnv_q, chg_q;

  // mode decode
  logic [TW-1:0] t_eff;
  assign t_eff = (t_i == '0 || int'(t_i) > TM) ? TW'(TM) : t_i;

  // decision for the current step
  logic          chg_c;
  logic [RW-1:0] lnew_c;
  logic [JW-1:0] ulim_c;
  always_comb begin
    chg_c  = (acc_q != '0) && (2 * int'(len_q) <= int'(r_q));
    lnew_c = chg_c ? RW'(int'(r_q) + 1 - int'(len_q)) : len_q;
    ulim_c = (int'(lnew_c) > TM) ? JW'(TM) : JW'(lnew_c);
  end

  // B is stored unshifted; kof_q is its power of x
  logic [SW-1:0] brd;
  always_comb begin
    int bi;
    bi  = int'(j_q) - 1 - int'(kof_q);
    brd = '0;
    if (bi >= 0 && bi <= TM) brd = bb_q[JW'(bi)];
  end

  // update cell: lam_j*gamma ^ b_(j-1)*delta
  logic [SW-1:0] u_z;
  bmks_pe #(.SW(SW), .POLY_TAIL(POLY_TAIL)) u_upd (
    .x1_i(lam_q[j_q]), .y1_i(gam_q), .x2_i(brd), .y2_i(dlt_q), .z_o(u_z)
  );

  // accumulate cell: next discrepancy, or evaluator terms
  logic [SW-1:0] a_x1, a_y1, a_z;
  always_comb begin
    int si;
    a_x1 = lnq_q;
    a_y1 = '0;
    si   = int'(r_q) + 1 - int'(lnj_q);
    if (st_q == ST_EVAL) begin
      a_x1 = lam_q[ej_q];
      a_y1 = syn_q[SIW'(int'(ei_q) - int'(ej_q))];
    end else if (si >= 0 && si < 2 * int'(t_q)) begin
      a_y1 = syn_q[SIW'(si)];
    end
  end

  bmks_pe #(.SW(SW), .POLY_TAIL(POLY_TAIL)) u_acc (
    .x1_i(a_x1), .y1_i(a_y1), .x2_i(acc_q), .y2_i(ONE), .z_o(a_z)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      for (int i = 0; i < NS; i++) syn_q[i] <= '0;
      for (int i = 0; i <= TM; i++) begin
        lam_q[i] <= '0;
        bb_q[i]  <= '0;
      end
      for (int i = 0; i < TM; i++) om_q[i] <= '0;
      len_q  <= '0;
      lnew_q <= '0;
      kof_q  <= '0;
      r_q    <= '0;
      t_q    <= TW'(TM);
      j_q    <= '0;
      lnj_q  <= '0;
      ei_q   <= '0;
      ej_q   <= '0;
      gam_q  <= '0;
      dlt_q  <= '0;
      acc_q  <= '0;
      lnq_q  <= '0;
      lnv_q  <= 1'b0;
      chg_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          for (int i = 0; i < NS; i++) syn_q[i] <= syn_i[i*SW +: SW];
          for (int i = 0; i <= TM; i++) begin
            lam_q[i] <= (i == 0) ? ONE : '0;
            bb_q[i]  <= (i == 0) ? ONE : '0;
          end
          for (int i = 0; i < TM; i++) om_q[i] <= '0;
          t_q   <= t_eff;
          len_q <= '0;
          kof_q <= '0;
          r_q   <= '0;
          gam_q <= ONE;
          acc_q <= syn_i[SW-1:0];  // first discrepancy is S_1
          st_q  <= ST_DEC;
        end
        ST_DEC: begin
          dlt_q  <= acc_q;
          chg_q  <= chg_c;
          lnew_q <= lnew_c;
          j_q    <= ulim_c;
          acc_q  <= '0;
          lnv_q  <= 1'b0;
          st_q   <= ST_UPD;
        end
        ST_UPD: begin
          // descending order: B read index stays below the write index
          lam_q[j_q] <= u_z;
          if (chg_q) bb_q[j_q] <= lam_q[j_q];
          lnq_q <= u_z;
          lnj_q <= j_q;
          lnv_q <= 1'b1;
          if (lnv_q) acc_q <= a_z;
          if (j_q == '0) st_q <= ST_TAIL;
          else           j_q  <= j_q - 1'b1;
        end
        ST_TAIL: begin
          len_q <= lnew_q;
          if (chg_q) begin
            gam_q <= dlt_q;
            kof_q <= '0;
          end else begin
            kof_q <= kof_q + 1'b1;
          end
          r_q <= r_q + 1'b1;
          if (int'(r_q) == 2 * int'(t_q) - 1) begin
            acc_q <= '0;
            ei_q  <= '0;
            ej_q  <= '0;
            st_q  <= ST_EVAL;
          end else begin
            acc_q <= a_z;
            st_q  <= ST_DEC;
          end
        end
        ST_EVAL: begin
          if (ej_q == ei_q) begin
            om_q[ei_q] <= a_z;
            acc_q      <= '0;
            ej_q       <= '0;
            if (int'(ei_q) == int'(t_q) - 1) st_q <= ST_DONE;
            else                             ei_q <= ei_q + 1'b1;
          end else begin
            acc_q <= a_z;
            ej_q  <= ej_q + 1'b1;
          end
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  for (genvar i = 0; i <= TM; i++) begin : g_lam
    assign lam_o[i*SW +: SW] = lam_q[i];
  end
  for (genvar i = 0; i < TM; i++) begin : g_omg
    assign omg_o[i*SW +: SW] = om_q[i];
  end

  assign ready_o = (st_q == ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign deg_o   = len_q;
  assign fail_o  = int'(len_q) > int'(t_q);

  assert_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && start_i) |=> !ready_o);
  assert_done_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_ready_after_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> ready_o);
  assert_hold_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !start_i) |=> ($stable(lam_o) && $stable(omg_o) && $stable(deg_o)));
  assert_lam0_nonzero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (lam_o[SW-1:0] != '0));
  assert_deg_monotonic_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |=> (len_q >= $past(len_q)));
  assert_zero_deg_ok_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && deg_o == '0) |-> !fail_o);
endmodule

// File: tb/bm_key_solver_tb_top.sv
module bm_key_solver_tb_top;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         start_i = 1'b0;
  logic [3:0]   t_i = 4'd8;
  logic [127:0] syn_i = '0;
  logic         ready_o, done_o, fail_o;
  logic [4:0]   deg_o;
  logic [71:0]  lam_o;
  logic [63:0]  omg_o;

  always #4 clk_i = ~clk_i;  // 125 MHz

  bm_key_solver dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .ready_o(ready_o),
    .t_i(t_i), .syn_i(syn_i), .done_o(done_o), .fail_o(fail_o),
    .deg_o(deg_o), .lam_o(lam_o), .omg_o(omg_o)
  );

  typedef struct packed {
    logic [3:0]       t;
    logic [3:0]       n;
    logic [7:0][7:0]  pos;
    logic [7:0][7:0]  val;
    logic             wfail;
    logic [4:0]       wdeg;
    logic             roots;
    logic [31:0]      t0;
  } sb_item_t;

  sb_item_t sb_q[$];
  int nchk = 0, nbad = 0, cyc = 0;
  int gexp[255];
  int glog[256];

  always @(posedge clk_i) cyc++;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] gmul(logic [7:0] a, logic [7:0] b);
    if (a == 0 || b == 0) return 8'd0;
    return 8'(gexp[(glog[a] + glog[b]) % 255]);
  endfunction

  function automatic logic [7:0] ginv(logic [7:0] a);
    return 8'(gexp[(255 - glog[a]) % 255]);
  endfunction

  function automatic logic [127:0] mk_syn(int t, int n, logic [7:0][7:0] p, logic [7:0][7:0] v);
    logic [127:0] s;
    logic [7:0]   a;
    s = '0;
    for (int j = 1; j <= 2 * t; j++) begin
      a = 8'd0;
      for (int k = 0; k < n; k++) a ^= gmul(v[k], 8'(gexp[(j * int'(p[k])) % 255]));
      s[8*(j-1) +: 8] = a;
    end
    return s;
  endfunction

  task automatic send(int tmode, int teff, int n, logic [7:0][7:0] p, logic [7:0][7:0] v,
                      logic [127:0] syn, bit wfail, int wdeg, bit roots);
    sb_item_t it;
    while (!ready_o) @(negedge clk_i);
    it.t = 4'(teff); it.n = 4'(n); it.pos = p; it.val = v;
    it.wfail = wfail; it.wdeg = 5'(wdeg); it.roots = roots; it.t0 = 32'(cyc);
    sb_q.push_back(it);
    t_i = 4'(tmode); syn_i = syn; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(!ready_o, "R2", "ready_o after accept", ready_o, 0);
  endtask

  task automatic rand_err(int t, int n, output logic [7:0][7:0] p, output logic [7:0][7:0] v);
    bit dup;
    int x;
    p = '0; v = '0;
    for (int k = 0; k < n; k++) begin
      do begin
        x = $urandom_range(0, 254);
        dup = 0;
        for (int q = 0; q < k; q++) if (int'(p[q]) == x) dup = 1;
      end while (dup);
      p[k] = 8'(x);
      v[k] = 8'($urandom_range(1, 255));
    end
  endtask

  task automatic run_err(int tmode, int teff, int n);
    logic [7:0][7:0] p, v;
    rand_err(teff, n, p, v);
    send(tmode, teff, n, p, v, mk_syn(teff, n, p, v), 0, n, 1);
  endtask

  // scoreboard monitor
  sb_item_t mi;
  logic     done_d = 1'b0;
  always @(negedge clk_i) begin
    logic [7:0] x, lv, dv, ov, ev;
    int lat, bound;
    if (done_d) begin
      chk(!done_o, "R3", "done_o width", done_o, 0);
      chk(ready_o, "R3", "ready_o after done", ready_o, 1);
    end
    done_d = done_o;
    if (rst_ni && done_o) begin
      if (sb_q.size() == 0) chk(0, "R3", "unexpected done", 1, 0);
      else begin
        mi = sb_q.pop_front();
        chk(fail_o == mi.wfail, "R6", "fail_o", fail_o, mi.wfail);
        chk(deg_o == mi.wdeg, "R4", "deg_o", deg_o, mi.wdeg);
        if (mi.roots) begin
          chk(lam_o[7:0] != 0, "R4", "lambda_0", lam_o[7:0], 1);
          for (int i = int'(mi.n) + 1; i <= 8; i++)
            chk(lam_o[8*i +: 8] == 0, "R4", "high lambda coeff", lam_o[8*i +: 8], 0);
          for (int i = int'(mi.n); i < 8; i++)
            chk(omg_o[8*i +: 8] == 0, "R5", "high omega coeff", omg_o[8*i +: 8], 0);
          for (int k = 0; k < int'(mi.n); k++) begin
            x  = 8'(gexp[(255 - int'(mi.pos[k])) % 255]);
            lv = 0; dv = 0; ov = 0;
            for (int i = 8; i >= 0; i--) lv = gmul(lv, x) ^ lam_o[8*i +: 8];
            for (int i = 7; i >= 0; i--) ov = gmul(ov, x) ^ omg_o[8*i +: 8];
            for (int i = 7; i >= 1; i -= 2) dv = gmul(gmul(dv, x), x) ^ lam_o[8*i +: 8];
            chk(lv == 0, "R4", "locator root", lv, 0);
            ev = (dv == 0) ? 8'd0 : gmul(ov, ginv(dv));
            chk(ev == mi.val[k], "R5", "error value", ev, mi.val[k]);
          end
          lat   = cyc - int'(mi.t0) - 1;
          bound = 2 * int'(mi.t) * (int'(mi.n) + 3) + int'(mi.t) * (int'(mi.t) + 1) / 2;
          chk(lat <= bound, "R8", "latency", lat, bound);
        end
      end
    end
  end

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(0, "WDG", "watchdog expired", cyc, 0);
    report();
  end

  initial begin
    logic [7:0][7:0] p, v;
    logic [71:0] l_s;
    logic [63:0] o_s;
    logic [4:0]  d_s;
    logic [127:0] s;
    int x = 1;
    for (int i = 0; i < 255; i++) begin
      gexp[i] = x;
      glog[x] = i;
      x = x << 1;
      if (x & 256) x ^= 'h11D;
    end
    glog[0] = 0;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(ready_o == 1, "R1", "ready_o", ready_o, 1);
    chk(done_o == 0, "R1", "done_o", done_o, 0);
    chk(deg_o == 0, "R1", "deg_o", deg_o, 0);
    chk(fail_o == 0, "R1", "fail_o", fail_o, 0);
    chk(lam_o == 0, "R1", "lam_o", lam_o[63:0], 0);
    chk(omg_o == 0, "R1", "omg_o", omg_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R9 all-zero syndromes
    p = '0; v = '0;
    send(8, 8, 0, p, v, '0, 0, 0, 1);
    // R4 single error at position 0, value 1, t=1
    p = '0; v = '0; v[0] = 8'd1;
    send(1, 1, 1, p, v, mk_syn(1, 1, p, v), 0, 1, 1);
    // R4 R5 R7 every mode, full error load and one fewer
    for (int t = 1; t <= 8; t++) begin
      run_err(t, t, t);
      run_err(t, t, t - 1);
    end
    // R7 junk above 2t ignored
    rand_err(2, 1, p, v);
    s = mk_syn(2, 1, p, v);
    s[127:32] = {3{32'hA5C3_1F7E}};
    send(2, 2, 1, p, v, s, 0, 1, 1);
    // R7 mode 0 selects t=8
    run_err(0, 8, 8);
    // R6 degree jumps past t: t=1, S1=0, S2=1 -> degree 2
    p = '0; v = '0;
    send(1, 1, 0, p, v, 128'h0100, 1, 2, 0);
    // R2 start while busy ignored
    run_err(4, 4, 3);
    @(negedge clk_i);
    syn_i = {16{8'h5A}}; t_i = 4'd8; start_i = 1'b1;
    chk(!ready_o, "R2", "busy during junk start", ready_o, 0);
    @(negedge clk_i);
    start_i = 1'b0;
    // random mix
    for (int k = 0; k < 40; k++) begin
      int t = $urandom_range(1, 8);
      run_err(t, t, $urandom_range(0, t));
    end
    // R3 outputs hold while idle
    while (sb_q.size() != 0 || !ready_o) @(negedge clk_i);
    l_s = lam_o; o_s = omg_o; d_s = deg_o;
    repeat (6) @(negedge clk_i);
    chk(lam_o == l_s, "R3", "lam_o hold", lam_o[63:0], l_s[63:0]);
    chk(omg_o == o_s, "R3", "omg_o hold", omg_o, o_s);
    chk(deg_o == d_s, "R3", "deg_o hold", deg_o, d_s);
    report();
  end
endmodule